// File: doc/BRIEF.md
# Masked Four-Level Interrupt Priority Resolver

This block gathers a bank of external interrupt request lines, catches a rising edge on each line in a sticky demand latch, and sorts the latches into four priority groups. The highest group that holds any pending demand is compared with a programmable mask threshold. When that group ranks above the threshold, the block raises a registered interrupt-present flag and a 2-bit code for the winning group.

Software reads the demand latches back directly. It can clear any chosen subset with a write-one-to-clear vector, drop every latch at once with a single clear-all command, and rewrite the threshold at any time. A demand that the mask held back is never lost. It stays latched, so lowering the threshold brings it out on the next output update. Vector fetch, context saving and the processor's interrupt entry sequence are handled elsewhere.

Top module: `irq_level_resolver`

## Requirements
- R1: After reset all demand latches read 0, `irqPresent` is 0, `irqLevel` is 0 and the mask threshold is 0.
- R2: A 0-to-1 transition on `irqIn[i]` between two consecutive clock edges sets demand latch i at the second edge. A line that stays high sets nothing further, and a line already high when reset ends counts as a rising edge.
- R3: Lines 0-5 belong to level 0, lines 6-11 to level 1, lines 12-17 to level 2 and lines 18-23 to level 3. Level 3 is the most urgent. `irqLevel` reports the highest level that holds any set latch.
- R4: A set demand latch stays set until a selective clear or a clear-all removes it.
- R5: The threshold is a 3-bit value. Pending level k is signalled only when k+1 is greater than the threshold, so threshold 0 passes every level and threshold 4 or more blocks all levels.
- R6: A threshold write that lowers the threshold below a pending level raises `irqPresent` at the next output update, with no new request needed.
- R7: `clrAll` high at an edge clears every demand latch.
- R8: `clrWe` high at an edge clears exactly those latches whose bit in `clrMask` is 1 and leaves the others unchanged.
- R9: A rising edge on a line in the same cycle as a selective clear or a clear-all of that line leaves the latch set.
- R10: `irqPresent` and `irqLevel` are registered. They reflect the latch and threshold state that was in place one edge earlier, so a change shows on the outputs one cycle after the latch or mask changes. `irqLevel` is 0 when `irqPresent` is 0.
- R11: `demandOut` shows the demand latches themselves, with no added delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irqIn | input | 24 | External request lines |
| clrWe | input | 1 | Apply selective clear this cycle |
| clrMask | input | 24 | Write-one-to-clear vector for the demand latches |
| clrAll | input | 1 | Clear every demand latch |
| maskWe | input | 1 | Load a new threshold |
| maskData | input | 3 | New threshold value |
| demandOut | output | 24 | Current demand latches |
| irqPresent | output | 1 | A pending level exceeds the threshold |
| irqLevel | output | 2 | Highest pending level while `irqPresent` is 1 |

## Verification
The assertions check four behaviours on every cycle. Each caught rising edge ends up in its latch. Latches never drop unless a clear was issued. A clear-all with no competing edge empties the bank. Any asserted interrupt names a level that was pending, that is the highest pending level, and that lies above the threshold in force at the time. The bench scenarios are needed for the cases these properties cannot reach: a line held high through a clear and not re-latched, a set and a clear landing on the same line in the same cycle, a threshold raised to silence a demand and then lowered to expose it again, and the exact one-cycle output latency. A cycle-accurate reference model exercises all of these alongside random traffic.

// File: rtl/irq_resolver_pkg.sv
package irq_resolver_pkg;
  // Control strobes handed from the control unit to the datapath
  typedef struct packed {
    logic clrAll;    // drop every latch
    logic clrSel;    // apply write-one-to-clear vector
    logic maskLoad;  // capture new threshold
  } ctrlStrobe_t;
endpackage

// File: rtl/irq_resolver_ctrl.sv
module irq_resolver_ctrl
  import irq_resolver_pkg::*;
#(
  parameter int NUM_LINES = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic                 clrWe,
  input  logic                 clrAll,
  input  logic                 maskWe,
  output logic [NUM_LINES-1:0] setVec,
  output ctrlStrobe_t          strobe
);
  logic [NUM_LINES-1:0] prevIn;

  // Sample of the lines from the previous edge; zero after reset so a
  // line high at reset release counts as a new request
  always_ff @(posedge clk) begin
    if (!rst_n) prevIn <= '0;
    else        prevIn <= irqIn;
  end

  assign setVec = irqIn & ~prevIn;

  always_comb begin
    strobe          = '0;
    strobe.clrAll   = clrAll;
    strobe.clrSel   = clrWe;
    strobe.maskLoad = maskWe;
  end
endmodule

// File: rtl/irq_resolver_dp.sv
module irq_resolver_dp
  import irq_resolver_pkg::*;
#(
  parameter int NUM_LINES  = 24,
  parameter int NUM_LEVELS = 4,
  parameter int LVL_W      = $clog2(NUM_LEVELS),
  parameter int MASK_W     = $clog2(NUM_LEVELS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] setVec,
  input  ctrlStrobe_t          strobe,
  input  logic [NUM_LINES-1:0] clrMask,
  input  logic [MASK_W-1:0]    maskData,
  output logic [NUM_LINES-1:0] demand,
  output logic                 irqPresent,
  output logic [LVL_W-1:0]     irqLevel
);
  localparam int PER_LVL = NUM_LINES / NUM_LEVELS;

  logic [NUM_LINES-1:0]  clrVec;
  logic [NUM_LINES-1:0]  demandNext;
  logic [MASK_W-1:0]     maskLvl;
  logic [NUM_LEVELS-1:0] lvlPend;
  logic [MASK_W-1:0]     topRank;   // 0 = nothing pending, else level+1

  // Latch update: clears first, then new edges win
  always_comb begin
    clrVec = '0;
    if (strobe.clrSel) clrVec = clrMask;
    if (strobe.clrAll) clrVec = '1;
    demandNext = (demand & ~clrVec) | setVec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      demand  <= '0;
      maskLvl <= '0;
    end else begin
      demand <= demandNext;
      if (strobe.maskLoad) maskLvl <= maskData;
    end
  end

  // Group reduction, one OR per level
  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
    assign lvlPend[g] = |demand[g*PER_LVL +: PER_LVL];
  end

  // Priority pick: later (higher) levels override
  always_comb begin
    topRank = '0;
    for (int g = 0; g < NUM_LEVELS; g++) begin
      if (lvlPend[g]) topRank = MASK_W'(g + 1);
    end
  end

  // Registered result
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irqPresent <= 1'b0;
      irqLevel   <= '0;
    end else begin
      irqPresent <= topRank > maskLvl;
      irqLevel   <= (topRank > maskLvl) ? LVL_W'(topRank - MASK_W'(1)) : '0;
    end
  end
endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver
  import irq_resolver_pkg::*;
#(
  parameter int NUM_LINES  = 24,
  parameter int NUM_LEVELS = 4,
  parameter int LVL_W      = $clog2(NUM_LEVELS),
  parameter int MASK_W     = $clog2(NUM_LEVELS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic                 clrWe,
  input  logic [NUM_LINES-1:0] clrMask,
  input  logic                 clrAll,
  input  logic                 maskWe,
  input  logic [MASK_W-1:0]    maskData,
  output logic [NUM_LINES-1:0] demandOut,
  output logic                 irqPresent,
  output logic [LVL_W-1:0]     irqLevel
);
  logic [NUM_LINES-1:0] setVec;
  ctrlStrobe_t          strobe;

  irq_resolver_ctrl #(.NUM_LINES(NUM_LINES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .irqIn(irqIn), .clrWe(clrWe),
    .clrAll(clrAll), .maskWe(maskWe), .setVec(setVec), .strobe(strobe)
  );

  irq_resolver_dp #(
    .NUM_LINES(NUM_LINES), .NUM_LEVELS(NUM_LEVELS),
    .LVL_W(LVL_W), .MASK_W(MASK_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .setVec(setVec), .strobe(strobe),
    .clrMask(clrMask), .maskData(maskData), .demand(demandOut),
    .irqPresent(irqPresent), .irqLevel(irqLevel)
  );
endmodule

// File: rtl/irq_level_resolver_chk.sv
module irq_level_resolver_chk #(
  parameter int NUM_LINES  = 24,
  parameter int NUM_LEVELS = 4,
  parameter int LVL_W      = 2,
  parameter int MASK_W     = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] irqIn,
  input logic                 clrWe,
  input logic                 clrAll,
  input logic                 maskWe,
  input logic [MASK_W-1:0]    maskData,
  input logic [NUM_LINES-1:0] demandOut,
  input logic                 irqPresent,
  input logic [LVL_W-1:0]     irqLevel
);
  localparam int PER_LVL = NUM_LINES / NUM_LEVELS;

  logic [NUM_LINES-1:0] prevChk, edgeQ;
  logic [MASK_W-1:0]    maskChk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prevChk <= '0;
      edgeQ   <= '0;
      maskChk <= '0;
    end else begin
      prevChk <= irqIn;
      edgeQ   <= irqIn & ~prevChk;
      if (maskWe) maskChk <= maskData;
    end
  end

  // R2, R9: every caught edge is visible in its latch
  p_edge_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (demandOut & edgeQ) == edgeQ);

  // R4: no clear issued, no latch drops
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clrWe && !clrAll) |=> ((demandOut & $past(demandOut)) == $past(demandOut)));

  // R7: clear-all with no competing edge empties the bank
  p_clear_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clrAll && ((irqIn & ~prevChk) == '0)) |=> (demandOut == '0));

  // R3: reported level was pending and nothing above it was
  p_level_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irqPresent |-> ((($past(demandOut) >> (int'(irqLevel) * PER_LVL)) & {PER_LVL{1'b1}}) != '0
                    && ($past(demandOut) >> ((int'(irqLevel) + 1) * PER_LVL)) == '0));

  // R5: reported level lies above the threshold in force
  p_above_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irqPresent |-> ((int'(irqLevel) + 1) > int'($past(maskChk))));

  // R10: level code is zero when nothing is signalled
  p_idle_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !irqPresent |-> (irqLevel == '0));
endmodule

bind irq_level_resolver irq_level_resolver_chk #(
  .NUM_LINES(NUM_LINES), .NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W), .MASK_W(MASK_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irqIn(irqIn), .clrWe(clrWe), .clrAll(clrAll),
  .maskWe(maskWe), .maskData(maskData), .demandOut(demandOut),
  .irqPresent(irqPresent), .irqLevel(irqLevel)
);

// File: tb/irq_level_resolver_tb.sv
`timescale 1ns/1ps
module irq_level_resolver_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] irqIn = '0;
  logic        clrWe = 1'b0;
  logic [23:0] clrMask = '0;
  logic        clrAll = 1'b0;
  logic        maskWe = 1'b0;
  logic [2:0]  maskData = '0;
  logic [23:0] demandOut;
  logic        irqPresent;
  logic [1:0]  irqLevel;

  int vectors = 0;
  int miscompares = 0;
  string curReq = "R1";

  always #2 clk = ~clk;

  irq_level_resolver u_dut (
    .clk(clk), .rst_n(rst_n), .irqIn(irqIn), .clrWe(clrWe), .clrMask(clrMask),
    .clrAll(clrAll), .maskWe(maskWe), .maskData(maskData),
    .demandOut(demandOut), .irqPresent(irqPresent), .irqLevel(irqLevel)
  );

  // Behavioural reference model
  bit [23:0] mPrev, mDem;
  int        mMask;
  bit        mPres;
  int        mLvl;

  always @(posedge clk) begin
    if (!rst_n) begin
      mPrev = '0; mDem = '0; mMask = 0; mPres = 0; mLvl = 0;
    end else begin
      int top;
      top = 0;
      for (int i = 0; i < 24; i++)
        if (mDem[i] && (i / 6 + 1) > top) top = i / 6 + 1;
      mPres = top > mMask;
      mLvl  = mPres ? top - 1 : 0;
      for (int i = 0; i < 24; i++) begin
        if (clrAll || (clrWe && clrMask[i])) mDem[i] = 1'b0;
        if (irqIn[i] && !mPrev[i]) mDem[i] = 1'b1;
      end
      if (maskWe) mMask = maskData;
      mPrev = irqIn;
    end
  end

  task automatic compare();
    vectors++;
    if (demandOut !== mDem || irqPresent !== mPres || irqLevel !== 2'(mLvl)) begin
      miscompares++;
      $display("FAIL %s: got dem=%h pres=%0b lvl=%0d exp dem=%h pres=%0b lvl=%0d",
               curReq, demandOut, irqPresent, irqLevel, mDem, mPres, mLvl);
    end
  endtask

  // Each step: compare at negedge, then drive the next stimulus
  task automatic step(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      compare();
      clrWe = 0; clrAll = 0; maskWe = 0;
    end
  endtask

  task automatic expect_out(bit pres, int lvl);
    vectors++;
    if (irqPresent !== pres || irqLevel !== 2'(lvl)) begin
      miscompares++;
      $display("FAIL %s: direct got pres=%0b lvl=%0d exp pres=%0b lvl=%0d",
               curReq, irqPresent, irqLevel, pres, lvl);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    curReq = "R1"; step(1);
    expect_out(0, 0);
    // R2: line 2 rises and stays high, then a clear while high
    curReq = "R2"; irqIn[2] = 1; step(4);
    clrWe = 1; clrMask = 24'h4; @(negedge clk); compare(); clrWe = 0; step(3);
    // R3: lines 7 then 20
    curReq = "R3"; irqIn[7] = 1; step(3);
    irqIn[20] = 1; step(3);
    expect_out(1, 3);
    // R4: nothing happens, latches stay
    curReq = "R4"; irqIn = '0; step(5);
    // R8: selective clear of line 20
    curReq = "R8"; clrWe = 1; clrMask = 24'h100000; step(3);
    expect_out(1, 1);
    // R5: threshold 2 silences level 1, threshold 4 silences all
    curReq = "R5"; maskWe = 1; maskData = 3'd2; step(3);
    expect_out(0, 0);
    irqIn[15] = 1; step(3);   // level 2 passes threshold 2
    expect_out(1, 2);
    maskWe = 1; maskData = 3'd4; step(3);
    expect_out(0, 0);
    maskWe = 1; maskData = 3'd7; step(2);
    // R6: lowering threshold exposes held demands
    curReq = "R6"; maskWe = 1; maskData = 3'd0; step(1);
    expect_out(0, 0);           // R10: not yet visible
    step(1);
    expect_out(1, 2);
    // R9: edge on line 13 together with clear of line 13
    curReq = "R9"; irqIn[13] = 1; clrWe = 1; clrMask = 24'h2000; step(3);
    irqIn[0] = 1; clrAll = 1; step(2);
    // R7: clear-all
    curReq = "R7"; irqIn = '0; step(1); clrAll = 1; step(3);
    expect_out(0, 0);
    // R10, R11: random traffic, compared every cycle
    curReq = "R10 R11 random";
    for (int c = 0; c < 600; c++) begin
      @(negedge clk);
      compare();
      irqIn    = irqIn ^ ($urandom() & $urandom() & $urandom());
      clrWe    = ($urandom_range(0, 5) == 0);
      clrMask  = $urandom();
      clrAll   = ($urandom_range(0, 30) == 0);
      maskWe   = ($urandom_range(0, 8) == 0);
      maskData = 3'($urandom());
    end
    step(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule